// File: doc/BRIEF.md
# Single-Precision Multiplier with Exponent-Only Overflow Decision

This block multiplies two 32-bit binary floating-point numbers and registers the product one clock after the operands arrive. Overflow is not found by looking at the finished product. It is decided before rounding from the two operand exponents alone. Any operation whose exponent sum could reach past the largest finite exponent is reported as overflow, whatever its fractions hold. As a result, some products that would fit are still saturated or trapped.

On a flagged overflow with the trap disabled, the result takes the largest finite magnitude, carries the product sign, and both the overflow and inexact flags are raised. With the trap enabled, the block raises an exception request instead and leaves its result register untouched. Normal products are rounded to nearest-even. Zero and subnormal operands flush to a signed zero. Infinities and NaNs follow fixed pass rules. A small output state machine holds one of three states: `OUT_IDLE` (nothing completed), `OUT_WRITE` (a result was written) and `OUT_TRAP` (a trapped overflow). Every cycle it moves to `OUT_IDLE` when `in_valid` is low, to `OUT_TRAP` when `in_valid` is high on a trapped overflow, and to `OUT_WRITE` for every other accepted operation.

Top module: `fmul_sp_early_ovf`

## Requirements
- R1: After an operation is accepted (`in_valid` high at a rising edge), `out_valid` is high for exactly the following cycle. `out_valid` is low in any cycle not preceded by an accepted operation. After reset, `result` is 0 and every output flag is low.
- R2: When both operands are normal (biased exponent 1..254), overflow is flagged exactly when the two biased exponents sum to 381 or more, that is, when the unbiased sum is at least 127. The fractions play no part. For example, 0x40A00000 times 0x7E05A364 is flagged.
- R3: On a flagged overflow with `trap_en` low, `result` becomes the sign XOR of the operands, followed by exponent 0xFE and all fraction bits set (0x7F7FFFFF or 0xFF7FFFFF). `exc_req` stays low.
- R4: Every flagged overflow raises both `ovf_flag` and `inx_flag`.
- R5: On a flagged overflow with `trap_en` high, `exc_req`, `ovf_flag` and `inx_flag` are high in the `out_valid` cycle, and `result` keeps the value it held before.
- R6: When two normal operands are not flagged, `result` is their product rounded to nearest, with ties going to the even significand. This includes a rounding carry that renormalises to the next exponent with zero fraction.
- R7: For an unflagged normal product, `inx_flag` is high exactly when a nonzero bit was discarded by rounding.
- R8: If either operand has biased exponent 0 (zero or subnormal) and neither has exponent 255, `result` is a zero with the XOR sign, and no flag is set.
- R9: If either operand is a NaN, or an infinity is multiplied by a zero or subnormal, `result` is 0x7FC00000. Any other product involving an infinity is an infinity with the XOR sign. No flag is set in either case.
- R10: When the normalised result exponent of a normal product falls to 0 or below, `result` is a zero with the XOR sign, `inx_flag` is high and `ovf_flag` is low.
- R11: `ovf_flag`, `inx_flag` and `exc_req` are low in every cycle where `out_valid` is low. Back-to-back operations each produce their own result in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and trap enable are valid this cycle |
| op_a | input | 32 | First operand, single-precision |
| op_b | input | 32 | Second operand, single-precision |
| trap_en | input | 1 | Overflow trap enable for this operation |
| result | output | 32 | Product register, unchanged by trapped operations |
| ovf_flag | output | 1 | Overflow was flagged for the completed operation |
| inx_flag | output | 1 | Completed operation was inexact |
| exc_req | output | 1 | Trapped overflow exception request |
| out_valid | output | 1 | One-cycle completion pulse |

## Verification
The product path is driven with random normal operands across the whole exponent range. Its results are compared with a reference built from a double-precision real product, rounded to single precision in the bench. The stimulus mix covers mid-range products, operands close enough to the overflow threshold to separate exponent sums of 380 from 381, and small exponents that drive the result into flush-to-zero. Directed vectors cover the following:
- the representable product that is still flagged, with the trap both enabled and disabled and with each sign;
- an exact tie that carries into the next exponent;
- zero, subnormal, infinity and NaN operands;
- back-to-back issue.

Together these tell pessimistic overflow apart from true overflow, a trapped write apart from a saturated one, and rounding apart from truncation.

// File: rtl/fmul_sp_pkg.sv
package fmul_sp_pkg;

    localparam int WORD_W  = 32;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int PROD_W  = 2 * SIG_W;
    localparam int EXT_W   = EXP_W + 3;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_TOP = (1 << EXP_W) - 1;
    // biased sum at which the unbiased sum reaches BIAS
    localparam int OVF_SUM = 3 * BIAS;

    typedef enum logic [1:0] {
        OPC_ZERO,
        OPC_NORM,
        OPC_INF,
        OPC_NAN
    } opclass_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
        opclass_e          cls;
    } operand_t;

    typedef enum logic [1:0] {
        OUT_IDLE,
        OUT_WRITE,
        OUT_TRAP
    } out_state_e;

endpackage

// File: rtl/fmul_sp_decode.sv
module fmul_sp_decode
    import fmul_sp_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output operand_t          opnd
);

    logic [EXP_W-1:0]  exp_field;
    logic [FRAC_W-1:0] frac_field;

    assign exp_field  = word[WORD_W-2 -: EXP_W];
    assign frac_field = word[FRAC_W-1:0];

    always_comb begin
        opnd.sign = word[WORD_W-1];
        opnd.exp  = exp_field;
        opnd.frac = frac_field;
        if (exp_field == '0) begin
            opnd.cls = OPC_ZERO;
        end else if (exp_field == EXP_W'(EXP_TOP)) begin
            opnd.cls = (frac_field != '0) ? OPC_NAN : OPC_INF;
        end else begin
            opnd.cls = OPC_NORM;
        end
    end

endmodule

// File: rtl/fmul_sp_exp_guard.sv
module fmul_sp_exp_guard
    import fmul_sp_pkg::*;
(
    input  logic [EXP_W-1:0]        exp_a,
    input  logic [EXP_W-1:0]        exp_b,
    output logic                    early_ovf,
    output logic signed [EXT_W-1:0] exp_base
);

    logic [EXT_W-1:0] exp_sum;

    assign exp_sum   = EXT_W'(exp_a) + EXT_W'(exp_b);
    // fractions deliberately ignored: a significand product up to 4 is assumed
    assign early_ovf = (exp_sum >= EXT_W'(OVF_SUM));
    assign exp_base  = $signed(exp_sum) - $signed(EXT_W'(BIAS));

endmodule

// File: rtl/fmul_sp_sig_round.sv
module fmul_sp_sig_round
    import fmul_sp_pkg::*;
(
    input  logic [FRAC_W-1:0]       frac_a,
    input  logic [FRAC_W-1:0]       frac_b,
    input  logic signed [EXT_W-1:0] exp_base,
    output logic [FRAC_W-1:0]       frac_out,
    output logic [EXP_W-1:0]        exp_out,
    output logic                    inexact,
    output logic                    underflow
);

    logic [PROD_W-1:0]       prod;
    logic                    norm;
    logic [FRAC_W-1:0]       frac_sel;
    logic                    guard_bit;
    logic                    sticky_bit;
    logic                    round_up;
    logic [FRAC_W:0]         frac_sum;
    logic                    carry;
    logic signed [EXT_W-1:0] exp_norm;

    assign prod = PROD_W'({1'b1, frac_a}) * PROD_W'({1'b1, frac_b});
    assign norm = prod[PROD_W-1];

    always_comb begin
        if (norm) begin
            frac_sel   = prod[PROD_W-2 -: FRAC_W];
            guard_bit  = prod[FRAC_W];
            sticky_bit = |prod[FRAC_W-1:0];
        end else begin
            frac_sel   = prod[PROD_W-3 -: FRAC_W];
            guard_bit  = prod[FRAC_W-1];
            sticky_bit = |prod[FRAC_W-2:0];
        end
    end

    assign round_up  = guard_bit & (sticky_bit | frac_sel[0]);
    assign frac_sum  = {1'b0, frac_sel} + (FRAC_W+1)'(round_up);
    assign carry     = frac_sum[FRAC_W];
    assign exp_norm  = exp_base + $signed({{(EXT_W-1){1'b0}}, norm});
    assign underflow = (exp_norm <= 0);
    assign inexact   = guard_bit | sticky_bit;
    assign frac_out  = carry ? '0 : frac_sum[FRAC_W-1:0];
    assign exp_out   = exp_norm[EXP_W-1:0] + EXP_W'(carry);

endmodule

// File: rtl/fmul_sp_early_ovf.sv
module fmul_sp_early_ovf
    import fmul_sp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              trap_en,
    output logic [WORD_W-1:0] result,
    output logic              ovf_flag,
    output logic              inx_flag,
    output logic              exc_req,
    output logic              out_valid
);

    localparam logic [WORD_W-1:0] QNAN_WORD = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [WORD_W-2:0] SAT_MAG   = {EXP_W'(EXP_TOP - 1), {FRAC_W{1'b1}}};

    operand_t                opnd_a;
    operand_t                opnd_b;
    logic                    early_ovf;
    logic signed [EXT_W-1:0] exp_base;
    logic [FRAC_W-1:0]       rnd_frac;
    logic [EXP_W-1:0]        rnd_exp;
    logic                    rnd_inexact;
    logic                    rnd_underflow;

    logic                    prod_sign;
    logic [WORD_W-1:0]       res_d;
    logic                    ovf_d;
    logic                    inx_d;
    logic                    trap_hit;

    out_state_e              state_q;
    out_state_e              state_d;

    fmul_sp_decode u_dec_a (.word(op_a), .opnd(opnd_a));
    fmul_sp_decode u_dec_b (.word(op_b), .opnd(opnd_b));

    fmul_sp_exp_guard u_guard (
        .exp_a     (opnd_a.exp),
        .exp_b     (opnd_b.exp),
        .early_ovf (early_ovf),
        .exp_base  (exp_base)
    );

    fmul_sp_sig_round u_round (
        .frac_a    (opnd_a.frac),
        .frac_b    (opnd_b.frac),
        .exp_base  (exp_base),
        .frac_out  (rnd_frac),
        .exp_out   (rnd_exp),
        .inexact   (rnd_inexact),
        .underflow (rnd_underflow)
    );

    assign prod_sign = opnd_a.sign ^ opnd_b.sign;

    // result selection, specials before the exponent guard
    always_comb begin
        res_d = {prod_sign, {(WORD_W-1){1'b0}}};
        ovf_d = 1'b0;
        inx_d = 1'b0;
        if (opnd_a.cls == OPC_NAN || opnd_b.cls == OPC_NAN ||
            (opnd_a.cls == OPC_INF && opnd_b.cls == OPC_ZERO) ||
            (opnd_b.cls == OPC_INF && opnd_a.cls == OPC_ZERO)) begin
            res_d = QNAN_WORD;
        end else if (opnd_a.cls == OPC_INF || opnd_b.cls == OPC_INF) begin
            res_d = {prod_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (opnd_a.cls == OPC_ZERO || opnd_b.cls == OPC_ZERO) begin
            res_d = {prod_sign, {(WORD_W-1){1'b0}}};
        end else if (early_ovf) begin
            res_d = {prod_sign, SAT_MAG};
            ovf_d = 1'b1;
            inx_d = 1'b1;
        end else if (rnd_underflow) begin
            res_d = {prod_sign, {(WORD_W-1){1'b0}}};
            inx_d = 1'b1;
        end else begin
            res_d = {prod_sign, rnd_exp, rnd_frac};
            inx_d = rnd_inexact;
        end
    end

    assign trap_hit = ovf_d & trap_en;

    // next-state logic
    always_comb begin
        state_d = OUT_IDLE;
        unique case (state_q)
            OUT_IDLE, OUT_WRITE, OUT_TRAP: begin
                if (in_valid) begin
                    state_d = trap_hit ? OUT_TRAP : OUT_WRITE;
                end
            end
            default: state_d = OUT_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OUT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result   <= '0;
            ovf_flag <= 1'b0;
            inx_flag <= 1'b0;
        end else begin
            if (state_d == OUT_WRITE) begin
                result <= res_d;
            end
            ovf_flag <= in_valid & ovf_d;
            inx_flag <= in_valid & inx_d;
        end
    end

    assign out_valid = (state_q != OUT_IDLE);
    assign exc_req   = (state_q == OUT_TRAP);

    // R1: one-cycle latency and no spurious completion
    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2: exponent-only decision for two normal operands
    assert_early_ovf_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_a[30:23] != 8'h00 && op_a[30:23] != 8'hFF &&
         op_b[30:23] != 8'h00 && op_b[30:23] != 8'hFF &&
         ({1'b0, op_a[30:23]} + {1'b0, op_b[30:23]}) >= 9'd381) |=> ovf_flag);

    // R3: saturated magnitude on an untrapped overflow
    assert_sat_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ovf_flag && !exc_req) |-> (result[30:0] == 31'h7F7FFFFF));

    // R4: overflow always inexact
    assert_ovf_inexact_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> inx_flag);

    // R5: trap holds the destination and reports overflow
    assert_trap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> ($stable(result) && ovf_flag && out_valid));

    // R11: flags quiet outside completion cycles
    assert_flags_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(ovf_flag || inx_flag || exc_req));

endmodule

// File: tb/fmul_sp_early_ovf_bench.sv
module fmul_sp_early_ovf_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        trap_en = 1'b0;
    logic [31:0] result;
    logic        ovf_flag;
    logic        inx_flag;
    logic        exc_req;
    logic        out_valid;

    int checks = 0;
    int failures = 0;
    logic [31:0] model_res = '0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fmul_sp_early_ovf u_fmul_sp_early_ovf (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .trap_en(trap_en), .result(result), .ovf_flag(ovf_flag), .inx_flag(inx_flag),
        .exc_req(exc_req), .out_valid(out_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] to_dbl(input logic [31:0] w);
        return {1'b0, 11'(w[30:23]) + 11'd896, w[22:0], 29'd0};
    endfunction

    // returns {ovf, inx, result}
    function automatic logic [33:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
        logic s;
        logic [7:0] ea, eb;
        logic nan_a, nan_b, inf_a, inf_b;
        real ra, rb, rp;
        logic [63:0] pd;
        int es;
        logic [24:0] m;
        logic g, st, up;
        s = a[31] ^ b[31];
        ea = a[30:23];
        eb = b[30:23];
        nan_a = (ea == 8'hFF) && (a[22:0] != 0);
        nan_b = (eb == 8'hFF) && (b[22:0] != 0);
        inf_a = (ea == 8'hFF) && !nan_a;
        inf_b = (eb == 8'hFF) && !nan_b;
        if (nan_a || nan_b || (inf_a && eb == 0) || (inf_b && ea == 0))
            return {2'b00, 32'h7FC00000};
        if (inf_a || inf_b) return {2'b00, s, 8'hFF, 23'd0};
        if (ea == 0 || eb == 0) return {2'b00, s, 31'd0};
        if (int'(ea) + int'(eb) >= 381) return {2'b11, s, 31'h7F7FFFFF};
        ra = $bitstoreal(to_dbl(a));
        rb = $bitstoreal(to_dbl(b));
        rp = ra * rb;
        pd = $realtobits(rp);
        es = int'(pd[62:52]) - 896;
        if (es <= 0) return {2'b01, s, 31'd0};
        m  = {2'b01, pd[51:29]};
        g  = pd[28];
        st = |pd[27:0];
        up = g & (st | m[0]);
        m  = m + 25'(up);
        if (m[24]) begin
            es = es + 1;
            m = '0;
        end
        return {1'b0, g | st, s, 8'(es), m[22:0]};
    endfunction

    task automatic do_op(input string req, input logic [31:0] a, input logic [31:0] b, input logic t);
        logic [33:0] r;
        logic trapped;
        r = ref_mul(a, b);
        trapped = r[33] & t;
        @(negedge clk);
        op_a = a; op_b = b; trap_en = t; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        if (!trapped) model_res = r[31:0];
        chk({req, " out_valid (R1)"}, 32'(out_valid), 32'd1);
        chk({req, " result"}, result, model_res);
        chk({req, " ovf_flag (R4)"}, 32'(ovf_flag), 32'(r[33]));
        chk({req, " inx_flag (R7)"}, 32'(inx_flag), 32'(r[32]));
        chk({req, " exc_req (R5)"}, 32'(exc_req), 32'(trapped));
        @(negedge clk);
        chk({req, " quiet after (R11)"}, {29'd0, out_valid, ovf_flag, inx_flag | exc_req}, 32'd0);
    endtask

    function automatic logic [31:0] rnd_op();
        int sel;
        logic [7:0] e;
        sel = int'($urandom % 16);
        if (sel < 10)      e = 8'(70 + $urandom % 110);
        else if (sel < 13) e = 8'(170 + $urandom % 84);
        else if (sel < 15) e = 8'(1 + $urandom % 60);
        else               e = (($urandom % 2) == 0) ? 8'h00 : 8'hFF;
        return {1'($urandom), e, 23'($urandom)};
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h1A2B3C4D);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset result", result, 32'd0);
        chk("R1 reset flags", {28'd0, out_valid, ovf_flag, inx_flag, exc_req}, 32'd0);

        // R2/R3: representable product still flagged
        do_op("R2 R3 pessimistic +", 32'h40A00000, 32'h7E05A364, 1'b0);
        chk("R3 saturated value", result, 32'h7F7FFFFF);
        do_op("R3 pessimistic -", 32'hC0A00000, 32'h7E05A364, 1'b0);
        chk("R3 negative saturated", result, 32'hFF7FFFFF);
        do_op("R6 seed value", 32'h40000000, 32'h40400000, 1'b0);
        chk("R6 exact 2*3", result, 32'h40C00000);
        do_op("R5 trapped", 32'h40A00000, 32'h7E05A364, 1'b1);
        chk("R5 result held", result, 32'h40C00000);
        // R2 threshold: sum 380 passes, 381 flagged
        do_op("R2 sum 380", 32'h7E800000, 32'h3F800000, 1'b0);
        chk("R2 sum 380 value", result, 32'h7E800000);
        do_op("R2 sum 381", 32'h7E800000, 32'h40000000, 1'b0);
        chk("R2 sum 381 saturates", result, 32'h7F7FFFFF);
        // R6 tie with carry into next exponent
        do_op("R6 tie carry", 32'h3F918E00, 32'h3FE12000, 1'b0);
        chk("R6 carry value", result, 32'h40000000);
        do_op("R7 thirds", 32'h3FAAAAAB, 32'h3FAAAAAB, 1'b0);
        // R8 zero and subnormal flush
        do_op("R8 zero", 32'h00000000, 32'h7F7FFFFF, 1'b0);
        do_op("R8 subnormal neg", 32'h80000005, 32'h7F7FFFFF, 1'b1);
        chk("R8 signed zero", result, 32'h80000000);
        // R9 specials
        do_op("R9 inf", 32'h7F800000, 32'hBF800000, 1'b0);
        chk("R9 neg inf", result, 32'hFF800000);
        do_op("R9 nan", 32'h7FC00001, 32'h3F800000, 1'b0);
        do_op("R9 inf*zero", 32'h7F800000, 32'h00000000, 1'b0);
        chk("R9 qnan", result, 32'h7FC00000);
        // R10 underflow flush
        do_op("R10 underflow", 32'h80800000, 32'h3F000000, 1'b0);
        chk("R10 neg zero", result, 32'h80000000);
        do_op("R10 min normal kept", 32'h00800000, 32'h3F800000, 1'b0);

        // R11 back-to-back
        @(negedge clk);
        op_a = 32'h40000000; op_b = 32'h40400000; trap_en = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        op_a = 32'h3F800000; op_b = 32'hC0800000;
        chk("R11 b2b first", result, 32'h40C00000);
        chk("R11 b2b first valid", 32'(out_valid), 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R11 b2b second", result, 32'hC0800000);
        chk("R11 b2b second valid", 32'(out_valid), 32'd1);
        @(negedge clk);
        chk("R1 pulse ends", 32'(out_valid), 32'd0);
        model_res = 32'hC0800000;

        for (int i = 0; i < 400; i++) begin
            do_op("R6 random", rnd_op(), rnd_op(), 1'($urandom % 4 == 0));
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule